// File: doc/BRIEF.md
# Key-locked control register bank

This block is a bank of 32-bit system control words reached over a simple register bus with separate read and write strobes and a byte address. A small lock machine guards most of the low part of the map: until software writes the correct 32-bit unlock key to offset 0x00, writes to the guarded window are discarded. Words at offset 0x104 and above stay writable whether the bank is locked or not.

Beyond plain storage, the bank has a few special words. Some words are status or scratch values that cannot be written. A strap word can have bits set through one offset and cleared through the revision offset. A random-number word returns a fresh value from an internal LFSR on every read. At reset, every word takes a fixed table value. The revision word, the two strap words and the initial lock state are then taken from input ports.

Every request is sorted into one access kind: `AK_NONE`, `AK_BAD`, `AK_KEY_WR`, `AK_LOCKED_WR`, `AK_RO_WR`, `AK_STRAP_SET`, `AK_STRAP_CLR`, `AK_PLAIN_WR`, `AK_RNG_RD` or `AK_PLAIN_RD`. The lock machine has two states, `LK_SHUT` and `LK_OPEN`. A key write with matching data moves it from `LK_SHUT` to `LK_OPEN`. A key write with any other data moves it from `LK_OPEN` to `LK_SHUT`. Every other cycle leaves the state where it is. Reset enters `LK_OPEN` when `key_open_init_i` is 1 and `LK_SHUT` otherwise.

Top module: `ctl_regbank`

## Requirements
- R1: The word index is addr_i[ADDR_W-1:2], so offset = index*4. A request with addr_i[1:0] not equal to 0 changes no state and pulses err_o. A misaligned read returns 0.
- R2: A write to offset 0x00 stores 1 in the key flag when wdata_i equals UNLOCK_KEY (default 0x5EC0A11C) and stores 0 otherwise. A read of 0x00 returns the flag in bit 0, with all other bits 0.
- R3: While the key flag is 0, a write to offsets 0x04 through 0x100 is dropped and pulses err_o. Offsets 0x104 and above are written normally whether the flag is set or not.
- R4: A request to an index at or above NREGS (default 112, so from offset 0x1C0) returns 0 on a read, changes nothing on a write, and pulses err_o in both cases.
- R5: Writes to the following offsets are ignored and pulse err_o: 0x14, 0x50 through 0x6C, 0x78, 0xE0 and 0xE4.
- R6: With STRAP_SET_MODE=1, a write to 0x70 ORs wdata_i into the strap word, and a write to 0x7C clears the strap bits that are 1 in wdata_i. Neither write pulses err_o, and the revision word at 0x7C never changes. With STRAP_SET_MODE=0, 0x70 is a plain word and a write to 0x7C is a read-only write.
- R7: Each read of 0x78 returns the next state of a 32-bit Galois LFSR and keeps that state. The LFSR steps as next = (s >> 1) ^ (s[0] ? 0x80200003 : 0), starts from RNG_SEED (default 0x1D872B41) at reset, and steps only on reads of 0x78. No enable bit is involved.
- R8: Reset values are: 0x04 = 0x00000F0F, 0x08 = 0x12340000, 0x14 = 0x000000A5, 0x50 = 0x5A5A0001, 0xE0 = 0xE4 = 0x000000FF, 0x104 = 0x80000000, and every other word 0. Reset then loads 0x7C from rev_i, 0x70 from strap1_i and 0xD0 from strap2_i, and the key flag from key_open_init_i. During reset rdata_o, rvalid_o and err_o are 0.
- R9: A read request gives rvalid_o=1 and rdata_o on the next cycle. In other cycles rvalid_o and rdata_o are 0. A write is visible to a read issued in the following cycle. err_o is a one-cycle pulse in the cycle after the offending request.
- R10: A cycle with both wr_en_i and rd_en_i set performs neither access, gives rvalid_o=0 and pulses err_o.
- R11: Any other write in range stores all 32 bits of wdata_i, and a later read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rev_i | input | 32 | Revision value loaded at reset |
| strap1_i | input | 32 | First strap value loaded at reset |
| strap2_i | input | 32 | Second strap value loaded at reset |
| key_open_init_i | input | 1 | Key flag value loaded at reset |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| err_o | output | 1 | One-cycle pulse for a dropped, out-of-range, misaligned, read-only or colliding request |

## Verification
The embedded properties check the following on every cycle:
- the key flag always matches the last key write, and holds between key writes;
- a locked write into the guarded window always raises the error pulse;
- out-of-range reads return zero;
- colliding strobes give no response;
- the revision word never changes;
- a strap-set write leaves every written bit set.

Only the bench's scenarios can show the behaviour that depends on history and data:
- the exact reset table;
- the read-only words keep their contents;
- the clear-through-revision path;
- the LFSR sequence;
- relocking;
- the differences between the two strap modes.

The bench shows these by running a behavioural model beside both mode variants.

// File: rtl/ctl_regbank_pkg.sv
`timescale 1ns/1ps
package ctl_regbank_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned IX_KEY      = 0;
    localparam int unsigned IX_FCNT     = 5;
    localparam int unsigned IX_VGA_LO   = 20;
    localparam int unsigned IX_VGA_HI   = 27;
    localparam int unsigned IX_STRAP1   = 28;
    localparam int unsigned IX_RNG      = 30;
    localparam int unsigned IX_REV      = 31;
    localparam int unsigned IX_STRAP2   = 52;
    localparam int unsigned IX_FREE0    = 56;
    localparam int unsigned IX_FREE1    = 57;
    localparam int unsigned IX_PROT_END = 65;

    typedef enum logic [3:0] {
        AK_NONE,
        AK_BAD,
        AK_KEY_WR,
        AK_LOCKED_WR,
        AK_RO_WR,
        AK_STRAP_SET,
        AK_STRAP_CLR,
        AK_PLAIN_WR,
        AK_RNG_RD,
        AK_PLAIN_RD
    } acc_kind_t;

    // Table of reset values, indexed by word
    function automatic logic [WORD_W-1:0] table_val(input int unsigned ix);
        logic [WORD_W-1:0] v;
        case (ix)
            1:        v = 32'h0000_0F0F;
            2:        v = 32'h1234_0000;
            IX_FCNT:  v = 32'h0000_00A5;
            IX_VGA_LO: v = 32'h5A5A_0001;
            IX_FREE0: v = 32'h0000_00FF;
            IX_FREE1: v = 32'h0000_00FF;
            IX_PROT_END: v = 32'h8000_0000;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_read_only(input logic [31:0] ix);
        return (ix == IX_FCNT) || (ix >= IX_VGA_LO && ix <= IX_VGA_HI) ||
               (ix == IX_RNG) || (ix == IX_FREE0) || (ix == IX_FREE1);
    endfunction

endpackage

// File: rtl/ctl_regbank_decode.sv
`timescale 1ns/1ps
module ctl_regbank_decode
    import ctl_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W         = 12,
    parameter int unsigned NREGS          = 112,
    parameter int unsigned STRAP_SET_MODE = 1
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              key_open_i,
    output acc_kind_t         kind_o,
    output logic [31:0]       ix_o
);

    localparam bit SET_MODE = (STRAP_SET_MODE != 0);

    logic aligned;
    logic in_range;

    assign ix_o     = 32'(addr_i[ADDR_W-1:2]);
    assign aligned  = (addr_i[1:0] == 2'b00);
    assign in_range = (ix_o < NREGS);

    // Priority: collision, then shape errors, then reads, then write rules
    always_comb begin
        kind_o = AK_NONE;
        if (wr_i && rd_i) begin
            kind_o = AK_BAD;
        end else if (wr_i || rd_i) begin
            if (!aligned || !in_range) begin
                kind_o = AK_BAD;
            end else if (rd_i) begin
                kind_o = (ix_o == IX_RNG) ? AK_RNG_RD : AK_PLAIN_RD;
            end else if (ix_o == IX_KEY) begin
                kind_o = AK_KEY_WR;
            end else if (!key_open_i && ix_o < IX_PROT_END) begin
                kind_o = AK_LOCKED_WR;
            end else if (is_read_only(ix_o)) begin
                kind_o = AK_RO_WR;
            end else if (ix_o == IX_STRAP1 && SET_MODE) begin
                kind_o = AK_STRAP_SET;
            end else if (ix_o == IX_REV) begin
                kind_o = SET_MODE ? AK_STRAP_CLR : AK_RO_WR;
            end else begin
                kind_o = AK_PLAIN_WR;
            end
        end
    end

endmodule

// File: rtl/ctl_regbank_lock.sv
`timescale 1ns/1ps
module ctl_regbank_lock #(
    parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_A11C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_open_i,
    input  logic        key_wr_i,
    input  logic [31:0] wdata_i,
    output logic        open_o
);

    typedef enum logic {LK_SHUT, LK_OPEN} lock_state_t;

    lock_state_t state_q, state_d;
    logic        match;

    assign match = (wdata_i == UNLOCK_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= init_open_i ? LK_OPEN : LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_wr_i && match)  state_d = LK_OPEN;
            LK_OPEN: if (key_wr_i && !match) state_d = LK_SHUT;
            default: state_d = LK_SHUT;
        endcase
    end

    assign open_o = (state_q == LK_OPEN);

    // R2: the flag follows the data of the last key write
    assert_key_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_i |=> (open_o == $past(wdata_i == UNLOCK_KEY)));

    // R2: the flag only moves on a key write
    assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr_i |=> $stable(open_o));

endmodule

// File: rtl/ctl_regbank_lfsr.sv
`timescale 1ns/1ps
module ctl_regbank_lfsr #(
    parameter logic [31:0] SEED = 32'h1D87_2B41,
    parameter logic [31:0] TAPS = 32'h8020_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    output logic [31:0] next_o
);

    logic [31:0] state_q;

    assign next_o = (state_q >> 1) ^ (state_q[0] ? TAPS : 32'h0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= SEED;
        else if (step_i) state_q <= next_o;
    end

    // R7: the generator never falls into the all-zero lockup state
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'h0);

endmodule

// File: rtl/ctl_regbank.sv
`timescale 1ns/1ps
module ctl_regbank
    import ctl_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W         = 12,
    parameter int unsigned NREGS          = 112,
    parameter int unsigned STRAP_SET_MODE = 1,
    parameter logic [31:0] UNLOCK_KEY     = 32'h5EC0_A11C,
    parameter logic [31:0] RNG_SEED       = 32'h1D87_2B41,
    parameter logic [31:0] RNG_TAPS       = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [31:0]       rev_i,
    input  logic [31:0]       strap1_i,
    input  logic [31:0]       strap2_i,
    input  logic              key_open_init_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o,
    output logic              err_o
);

    localparam int unsigned SLOT_W = $clog2(NREGS);

    acc_kind_t         kind;
    logic [31:0]       req_ix;
    logic [SLOT_W-1:0] slot;
    logic              key_open;
    logic [31:0]       rng_next;
    logic [31:0]       regs_q [NREGS];

    assign slot = req_ix[SLOT_W-1:0];

    ctl_regbank_decode #(
        .ADDR_W(ADDR_W), .NREGS(NREGS), .STRAP_SET_MODE(STRAP_SET_MODE)
    ) decode_i (
        .wr_i(wr_en_i), .rd_i(rd_en_i), .addr_i(addr_i),
        .key_open_i(key_open), .kind_o(kind), .ix_o(req_ix)
    );

    ctl_regbank_lock #(.UNLOCK_KEY(UNLOCK_KEY)) lock_i (
        .clk(clk), .rst_n(rst_n), .init_open_i(key_open_init_i),
        .key_wr_i(kind == AK_KEY_WR), .wdata_i(wdata_i), .open_o(key_open)
    );

    ctl_regbank_lfsr #(.SEED(RNG_SEED), .TAPS(RNG_TAPS)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .step_i(kind == AK_RNG_RD), .next_o(rng_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= table_val(i);
            regs_q[IX_REV]    <= rev_i;
            regs_q[IX_STRAP1] <= strap1_i;
            regs_q[IX_STRAP2] <= strap2_i;
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            rvalid_o <= rd_en_i && !wr_en_i;
            err_o    <= (kind == AK_BAD) || (kind == AK_LOCKED_WR) || (kind == AK_RO_WR);
            rdata_o  <= '0;
            unique case (kind)
                AK_PLAIN_WR:  regs_q[slot] <= wdata_i;
                AK_STRAP_SET: regs_q[IX_STRAP1] <= regs_q[IX_STRAP1] | wdata_i;
                AK_STRAP_CLR: regs_q[IX_STRAP1] <= regs_q[IX_STRAP1] & ~wdata_i;
                AK_PLAIN_RD:  rdata_o <= (req_ix == IX_KEY) ? {31'h0, key_open} : regs_q[slot];
                AK_RNG_RD:    rdata_o <= rng_next;
                default:      ;
            endcase
        end
    end

    // R3: a write into the guarded window while locked is reported
    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rd_en_i && addr_i[1:0] == 2'b00 && req_ix != 0 &&
         req_ix < IX_PROT_END && !key_open) |=> err_o);

    // R4: out-of-range reads return zero with an error
    assert_oob_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && req_ix >= NREGS) |=> (rdata_o == 32'h0 && err_o));

    // R6: the revision word is never altered by a write
    assert_rev_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> $stable(regs_q[IX_REV]));

    // R9: a response follows exactly the cycles with a lone read strobe
    assert_rvalid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rvalid_o == $past(rd_en_i && !wr_en_i)));

    // R10: colliding strobes give an error and no response
    assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_en_i) |=> (err_o && !rvalid_o));

    generate
        if (STRAP_SET_MODE != 0) begin : g_strap_chk
            // R6: every bit written through the set offset ends up set
            assert_strap_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en_i && !rd_en_i && addr_i[1:0] == 2'b00 && req_ix == IX_STRAP1 && key_open)
                |=> ((regs_q[IX_STRAP1] & $past(wdata_i)) == $past(wdata_i)));
        end
    endgenerate

endmodule

// File: tb/ctl_regbank_tb_top.sv
`timescale 1ns/1ps
module ctl_regbank_tb_top;

    localparam int NREGS = 112;
    localparam logic [31:0] KEY  = 32'h5EC0_A11C;
    localparam logic [31:0] SEED = 32'h1D87_2B41;
    localparam logic [31:0] TAPS = 32'h8020_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, kinit = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0, rev = '0, strap1 = '0, strap2 = '0;
    logic [31:0] rdata_w [2];
    logic        rvalid_w [2];
    logic        err_w [2];

    int checks = 0;
    int fails  = 0;

    // Model state per instance: 0 = set mode on (dut_i), 1 = set mode off
    logic [31:0] mr [2][NREGS];
    logic        mk [2];
    logic [31:0] ml [2];
    logic [31:0] e_rdata [2];
    logic        e_rvalid [2];
    logic        e_err [2];

    always #2.5 clk = ~clk;

    ctl_regbank #(.STRAP_SET_MODE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rev_i(rev), .strap1_i(strap1), .strap2_i(strap2),
        .key_open_init_i(kinit), .rdata_o(rdata_w[0]), .rvalid_o(rvalid_w[0]),
        .err_o(err_w[0]));

    ctl_regbank #(.STRAP_SET_MODE(0)) dut_m0_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rev_i(rev), .strap1_i(strap1), .strap2_i(strap2),
        .key_open_init_i(kinit), .rdata_o(rdata_w[1]), .rvalid_o(rvalid_w[1]),
        .err_o(err_w[1]));

    function automatic logic [31:0] reset_word(int ix);
        case (ix)
            1: return 32'h0000_0F0F;
            2: return 32'h1234_0000;
            5: return 32'h0000_00A5;
            20: return 32'h5A5A_0001;
            56, 57: return 32'h0000_00FF;
            65: return 32'h8000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit no_write(int ix);
        return ix == 5 || (ix >= 20 && ix <= 27) || ix == 30 || ix == 56 || ix == 57;
    endfunction

    function automatic logic [31:0] lfsr_step(logic [31:0] s);
        return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
    endfunction

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < NREGS; i++) mr[m][i] = reset_word(i);
            mr[m][31] = rev; mr[m][28] = strap1; mr[m][52] = strap2;
            mk[m] = kinit; ml[m] = SEED;
            e_rdata[m] = '0; e_rvalid[m] = 1'b0; e_err[m] = 1'b0;
        end
    endtask

    task automatic model_step(int m, bit w, bit r, logic [11:0] a, logic [31:0] d);
        int ix;
        bit bad;
        ix = int'(a >> 2);
        bad = (a[1:0] != 2'b00) || (ix >= NREGS);
        e_rdata[m] = '0; e_rvalid[m] = 1'b0; e_err[m] = 1'b0;
        if (!w && !r) return;
        if (w && r) begin e_err[m] = 1'b1; return; end
        if (r) begin
            e_rvalid[m] = 1'b1;
            if (bad) e_err[m] = 1'b1;
            else if (ix == 30) begin ml[m] = lfsr_step(ml[m]); e_rdata[m] = ml[m]; end
            else if (ix == 0) e_rdata[m] = {31'h0, mk[m]};
            else e_rdata[m] = mr[m][ix];
            return;
        end
        if (bad) begin e_err[m] = 1'b1; return; end
        if (ix == 0) begin mk[m] = (d == KEY); return; end
        if (!mk[m] && ix < 65) begin e_err[m] = 1'b1; return; end
        if (no_write(ix)) begin e_err[m] = 1'b1; return; end
        if (ix == 28 && m == 0) mr[m][28] = mr[m][28] | d;
        else if (ix == 31) begin
            if (m == 0) mr[m][28] = mr[m][28] & ~d;
            else e_err[m] = 1'b1;
        end else mr[m][ix] = d;
    endtask

    task automatic compare(string tag, logic [11:0] a);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (rvalid_w[m] !== e_rvalid[m] || err_w[m] !== e_err[m] || rdata_w[m] !== e_rdata[m]) begin
                fails++;
                $display("FAIL %s inst%0d addr=%h: got rv=%0b err=%0b rd=%h, expected rv=%0b err=%0b rd=%h",
                         tag, m, a, rvalid_w[m], err_w[m], rdata_w[m], e_rvalid[m], e_err[m], e_rdata[m]);
            end
        end
    endtask

    // Called at a falling edge: drive, model, wait one clock, compare
    task automatic op(string tag, bit w, bit r, logic [11:0] a, logic [31:0] d);
        wr = w; rd = r; addr = a; wdata = d;
        for (int m = 0; m < 2; m++) model_step(m, w, r, a, d);
        @(negedge clk);
        compare(tag, a);
    endtask

    task automatic wr_op(string tag, logic [11:0] a, logic [31:0] d); op(tag, 1, 0, a, d); endtask
    task automatic rd_op(string tag, logic [11:0] a); op(tag, 0, 1, a, 32'h0); endtask

    task automatic do_reset(logic ki, logic [31:0] rv, logic [31:0] s1, logic [31:0] s2);
        wr = 0; rd = 0; rst_n = 1'b0;
        kinit = ki; rev = rv; strap1 = s1; strap2 = s2;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        compare("R8", 12'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hang, expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0, 32'h0A01_0302, 32'h0000_F0F0, 32'h0000_0033);
        // R8 reset contents
        rd_op("R8", 12'h000); rd_op("R8", 12'h004); rd_op("R8", 12'h008);
        rd_op("R8", 12'h00C); rd_op("R8", 12'h014); rd_op("R8", 12'h050);
        rd_op("R8", 12'h070); rd_op("R8", 12'h07C); rd_op("R8", 12'h0D0);
        rd_op("R8", 12'h0E0); rd_op("R8", 12'h0E4); rd_op("R8", 12'h104);
        // R3 locked window and open upper region
        wr_op("R3", 12'h004, 32'hDEAD_BEEF); rd_op("R3", 12'h004);
        wr_op("R3", 12'h100, 32'h1357_9BDF); rd_op("R3", 12'h100);
        wr_op("R3", 12'h104, 32'h1111_2222); rd_op("R3", 12'h104);
        wr_op("R3", 12'h1BC, 32'hAAAA_5555); rd_op("R3", 12'h1BC);
        // R2 key handling
        wr_op("R2", 12'h000, 32'h1234_5678); rd_op("R2", 12'h000);
        wr_op("R2", 12'h000, KEY);           rd_op("R2", 12'h000);
        // R11 and R9 write then immediate read
        wr_op("R11", 12'h004, 32'hCAFE_0001); rd_op("R9", 12'h004);
        wr_op("R11", 12'h040, 32'hFFFF_FFFF); rd_op("R11", 12'h040);
        wr_op("R11", 12'h040, 32'h0000_0000); rd_op("R11", 12'h040);
        op("R9", 0, 0, 12'h000, 32'h0);
        // R5 read-only words
        foreach (ro_list[k]) begin
            wr_op("R5", ro_list[k], 32'h0BAD_F00D); rd_op("R5", ro_list[k]);
        end
        // R6 strap set and clear
        wr_op("R6", 12'h070, 32'h0F00_000F); rd_op("R6", 12'h070);
        wr_op("R6", 12'h07C, 32'h0000_00FF); rd_op("R6", 12'h070);
        rd_op("R6", 12'h07C);
        // R7 random word
        rd_op("R7", 12'h078); rd_op("R7", 12'h078); rd_op("R7", 12'h078);
        op("R7", 0, 0, 12'h078, 32'h0); rd_op("R7", 12'h078);
        // R4 and R1 bad addresses
        rd_op("R4", 12'h1C0); wr_op("R4", 12'h1C4, 32'h5); rd_op("R4", 12'hFFC);
        wr_op("R1", 12'h006, 32'h77); rd_op("R1", 12'h004); rd_op("R1", 12'h005);
        // R10 collision
        op("R10", 1, 1, 12'h004, 32'h99); rd_op("R10", 12'h004);
        // R3 relock
        wr_op("R3", 12'h000, 32'h0); wr_op("R3", 12'h008, 32'h1); rd_op("R3", 12'h008);
        rd_op("R2", 12'h000);
        // R8 second reset with the key flag preset
        do_reset(1'b1, 32'h0B02_0001, 32'h00FF_0000, 32'hC000_0001);
        rd_op("R8", 12'h000); wr_op("R8", 12'h008, 32'h0202_0202); rd_op("R8", 12'h008);
        rd_op("R8", 12'h07C); rd_op("R8", 12'h070); rd_op("R8", 12'h0D0);
        rd_op("R7", 12'h078);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    logic [11:0] ro_list [6] = '{12'h014, 12'h050, 12'h06C, 12'h078, 12'h0E0, 12'h0E4};

endmodule